// File: doc/BRIEF.md
# BCD Time-of-Day Register File

This block keeps the calendar time (seconds, minutes, hours, weekday, date, month and two-digit year) as packed BCD bytes. The fields advance once for every pulse on a one-second strobe input, carrying from each field into the next. They roll over at month ends, with a leap-year February, and at the turn of the century.

Software reaches the time through eight byte-wide registers at consecutive offsets. A write is checked against the legal range of the field it targets, and a value outside that range leaves the field as it was. The seconds register holds a stop flag that pauses the count. A control register always keeps a fixed pattern in some of its bits. The weekday register also holds a century flag that is set and cleared only by software.

Top module: `tod_regfile`

## Requirements
- R1: Register offsets are 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday/century, 5 date, 6 month, 7 year. After reset they read 0x90, 0x00, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00, and the stop flag is clear.
- R2: A control write stores the written byte with bit 5 cleared and bits 7 and 4 set. A read returns the stored byte.
- R3: A seconds write always stores written bit 7 as the stop flag. It updates the seconds only when bits 6:0 form valid BCD in 00..59.
- R4: A seconds read returns the stop flag in bit 7 and the BCD seconds in bits 6:0.
- R5: While the stop flag is set, strobes do not change any time field. After the flag is cleared, counting continues from the held value.
- R6: A minutes write uses bits 6:0 and must be BCD 00..59. An hours write uses bits 5:0 and must be BCD 00..23. Any other value is ignored.
- R7: A weekday write always stores written bit 6 as the century flag. It updates the weekday from bits 2:0 only when that value is 1..7. A read returns the century flag in bit 6 and the weekday in bits 2:0, with all other bits zero.
- R8: A date write uses bits 4:0 and must be nonzero valid BCD. A month write uses bits 4:0 and must be BCD 01..12. A year write uses all 8 bits and must be BCD 00..99. Invalid values are ignored.
- R9: Each running strobe adds one second. 59 seconds wrap to 00 and carry into minutes, 59 minutes wrap and carry into hours, and 23 hours wrap and advance both the date and the weekday. The weekday goes from 7 back to 1.
- R10: After the last day of a month, the date returns to 01 and the month advances. Months 04, 06, 09 and 11 have 30 days and the rest have 31. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R11: February has 29 days when the year value is divisible by 4 (year 00 included), and 28 days otherwise.
- R12: When a strobe and a write fall in the same cycle, the strobe advances the time first and the write then replaces the field it addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register (combinational) |

## Verification
A wrong carry or wrong month length does not show up right away. It appears only when the affected field is read after the strobe that should have carried, for example a date that fails to return to 01 after the last day of a month. A write that is accepted when it should be dropped corrupts a field. The corrupt value is visible in the first read of that offset after the write clock edge, and it can also push a later carry into a field that should not yet have moved. A stop flag that does not hold the count shows on the seconds readback after the very next strobe.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_SEC   = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_MIN   = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_HOUR  = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_WDAY  = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_DATE  = 3'd5;
    localparam logic [ADDR_W-1:0] OFF_MONTH = 3'd6;
    localparam logic [ADDR_W-1:0] OFF_YEAR  = 3'd7;

    localparam logic [DATA_W-1:0] CTRL_SET   = 8'h90;
    localparam logic [DATA_W-1:0] CTRL_CLEAR = 8'hA0;

    typedef logic [DATA_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t ctrl;
        logic stop;
        bcd_t sec;
        bcd_t min;
        bcd_t hour;
        logic cent;
        bcd_t wday;
        bcd_t date;
        bcd_t month;
        bcd_t year;
    } tod_state_t;

    function automatic logic bcd_in_range(bcd_t v, bcd_t lo, bcd_t hi);
        return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
    endfunction

    function automatic bcd_t bcd_plus_one(bcd_t v);
        bcd_t r;
        if (v[3:0] >= 4'd9) begin
            r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

    // True when a two-digit BCD year is a multiple of four.
    function automatic logic bcd_leap(bcd_t y);
        logic tens_odd;
        tens_odd = y[4];
        if (tens_odd) begin
            return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        end
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

endpackage

// File: rtl/tod_bcd_step.sv
module tod_bcd_step
    import tod_pkg::*;
#(
    parameter bcd_t LO = 8'h00
) (
    input  bcd_t val,
    input  logic en,
    input  bcd_t hi,
    output bcd_t nxt,
    output logic wrap
);
    always_comb begin
        wrap = en && (val >= hi);
        if (!en) begin
            nxt = val;
        end else if (wrap) begin
            nxt = LO;
        end else begin
            nxt = bcd_plus_one(val);
        end
    end
endmodule

// File: rtl/tod_month_days.sv
module tod_month_days
    import tod_pkg::*;
(
    input  bcd_t month,
    input  bcd_t year,
    output bcd_t last_day
);
    always_comb begin
        unique case (month)
            8'h02:                      last_day = bcd_leap(year) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/tod_regfile.sv
module tod_regfile
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    tod_state_t st_q, st_d;

    logic run;
    bcd_t last_day;
    bcd_t sec_n, min_n, hour_n, wday_n, date_n, month_n, year_n;
    logic sec_w, min_w, hour_w, wday_w, date_w, month_w, year_w;

    assign run = sec_tick && !st_q.stop;

    tod_month_days u_mdays (
        .month(st_q.month), .year(st_q.year), .last_day(last_day)
    );

    tod_bcd_step #(.LO(8'h00)) u_sec (
        .val(st_q.sec), .en(run), .hi(8'h59), .nxt(sec_n), .wrap(sec_w)
    );
    tod_bcd_step #(.LO(8'h00)) u_min (
        .val(st_q.min), .en(sec_w), .hi(8'h59), .nxt(min_n), .wrap(min_w)
    );
    tod_bcd_step #(.LO(8'h00)) u_hour (
        .val(st_q.hour), .en(min_w), .hi(8'h23), .nxt(hour_n), .wrap(hour_w)
    );
    tod_bcd_step #(.LO(8'h01)) u_wday (
        .val(st_q.wday), .en(hour_w), .hi(8'h07), .nxt(wday_n), .wrap(wday_w)
    );
    tod_bcd_step #(.LO(8'h01)) u_date (
        .val(st_q.date), .en(hour_w), .hi(last_day), .nxt(date_n), .wrap(date_w)
    );
    tod_bcd_step #(.LO(8'h01)) u_month (
        .val(st_q.month), .en(date_w), .hi(8'h12), .nxt(month_n), .wrap(month_w)
    );
    tod_bcd_step #(.LO(8'h00)) u_year (
        .val(st_q.year), .en(month_w), .hi(8'h99), .nxt(year_n), .wrap(year_w)
    );

    // Next state: advance first, then let a write replace its field.
    always_comb begin
        st_d       = st_q;
        st_d.sec   = sec_n;
        st_d.min   = min_n;
        st_d.hour  = hour_n;
        st_d.wday  = wday_n;
        st_d.date  = date_n;
        st_d.month = month_n;
        st_d.year  = year_n;
        if (wr_en) begin
            unique case (addr)
                OFF_CTRL: st_d.ctrl = (wdata & ~CTRL_CLEAR) | CTRL_SET;
                OFF_SEC: begin
                    st_d.stop = wdata[7];
                    if (bcd_in_range({1'b0, wdata[6:0]}, 8'h00, 8'h59))
                        st_d.sec = {1'b0, wdata[6:0]};
                end
                OFF_MIN: begin
                    if (bcd_in_range({1'b0, wdata[6:0]}, 8'h00, 8'h59))
                        st_d.min = {1'b0, wdata[6:0]};
                end
                OFF_HOUR: begin
                    if (bcd_in_range({2'b00, wdata[5:0]}, 8'h00, 8'h23))
                        st_d.hour = {2'b00, wdata[5:0]};
                end
                OFF_WDAY: begin
                    st_d.cent = wdata[6];
                    if (wdata[2:0] != 3'd0)
                        st_d.wday = {5'd0, wdata[2:0]};
                end
                OFF_DATE: begin
                    if (bcd_in_range({3'b000, wdata[4:0]}, 8'h01, 8'h19))
                        st_d.date = {3'b000, wdata[4:0]};
                end
                OFF_MONTH: begin
                    if (bcd_in_range({3'b000, wdata[4:0]}, 8'h01, 8'h12))
                        st_d.month = {3'b000, wdata[4:0]};
                end
                default: begin
                    if (bcd_in_range(wdata, 8'h00, 8'h99))
                        st_d.year = wdata;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl  <= CTRL_SET;
            st_q.stop  <= 1'b0;
            st_q.sec   <= 8'h00;
            st_q.min   <= 8'h00;
            st_q.hour  <= 8'h00;
            st_q.cent  <= 1'b0;
            st_q.wday  <= 8'h01;
            st_q.date  <= 8'h01;
            st_q.month <= 8'h01;
            st_q.year  <= 8'h00;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (addr)
            OFF_CTRL:  rdata = st_q.ctrl;
            OFF_SEC:   rdata = {st_q.stop, st_q.sec[6:0]};
            OFF_MIN:   rdata = st_q.min;
            OFF_HOUR:  rdata = st_q.hour;
            OFF_WDAY:  rdata = {1'b0, st_q.cent, 3'b000, st_q.wday[2:0]};
            OFF_DATE:  rdata = st_q.date;
            OFF_MONTH: rdata = st_q.month;
            default:   rdata = st_q.year;
        endcase
    end

    logic unused_wraps;
    assign unused_wraps = wday_w ^ year_w;
endmodule

// File: rtl/tod_regfile_chk.sv
module tod_regfile_chk
    import tod_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input tod_state_t        st
);
    // R2: the forced control pattern survives every write
    a_r2_ctrl_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == OFF_CTRL |=> st.ctrl[7] && st.ctrl[4] && !st.ctrl[5]);

    // R3: seconds never leave the legal BCD range
    a_r3_sec_legal: assert property (@(posedge clk) disable iff (!rst_n)
        st.sec <= 8'h59 && st.sec[3:0] <= 4'd9);

    // R5: a stopped clock holds its time when nothing writes it
    a_r5_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        st.stop && !wr_en |=> $stable(st.sec) && $stable(st.min) && $stable(st.hour)
                              && $stable(st.date));

    // R6: hours stay within 00..23
    a_r6_hour_legal: assert property (@(posedge clk) disable iff (!rst_n)
        st.hour <= 8'h23 && st.hour[3:0] <= 4'd9);

    // R6: an out-of-range minutes write leaves minutes alone when no carry arrives
    a_r6_bad_min_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == OFF_MIN && wdata[6:0] > 7'h59 && !sec_tick |=> $stable(st.min));

    // R8: month stays within 01..12
    a_r8_month_legal: assert property (@(posedge clk) disable iff (!rst_n)
        st.month >= 8'h01 && st.month <= 8'h12);

    // R9: minutes move only on a seconds carry or a write
    a_r9_min_carry_only: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && (!sec_tick || st.stop || st.sec != 8'h59) |=> $stable(st.min));
endmodule

bind tod_regfile tod_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .st(st_q)
);

// File: tb/tod_regfile_bench.sv
`timescale 1ns/1ps
module tod_regfile_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tod_regfile u_tod_regfile (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic expect_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic next_day();
        wr(3'd1, 8'h59);
        wr(3'd2, 8'h59);
        wr(3'd3, 8'h23);
        tick();
    endtask

    task automatic t_reset();
        expect_reg("R1 ctrl", 3'd0, 8'h90);
        expect_reg("R1 sec", 3'd1, 8'h00);
        expect_reg("R1 min", 3'd2, 8'h00);
        expect_reg("R1 hour", 3'd3, 8'h00);
        expect_reg("R1 wday", 3'd4, 8'h01);
        expect_reg("R1 date", 3'd5, 8'h01);
        expect_reg("R1 month", 3'd6, 8'h01);
        expect_reg("R1 year", 3'd7, 8'h00);
    endtask

    task automatic t_ctrl();
        wr(3'd0, 8'hFF); expect_reg("R2 ctrl ff", 3'd0, 8'hDF);
        wr(3'd0, 8'h00); expect_reg("R2 ctrl 00", 3'd0, 8'h90);
        wr(3'd0, 8'h2B); expect_reg("R2 ctrl 2b", 3'd0, 8'h9B);
    endtask

    task automatic t_seconds();
        wr(3'd1, 8'h45); expect_reg("R3 sec valid", 3'd1, 8'h45);
        wr(3'd1, 8'h60); expect_reg("R3 sec 60 dropped", 3'd1, 8'h45);
        wr(3'd1, 8'h5A); expect_reg("R3 sec bad nibble", 3'd1, 8'h45);
        wr(3'd1, 8'hB0); expect_reg("R4 sec read with stop", 3'd1, 8'hB0);
        tick(); tick(); tick();
        expect_reg("R5 stopped", 3'd1, 8'hB0);
        wr(3'd1, 8'h7F); expect_reg("R3 stop cleared, value dropped", 3'd1, 8'h30);
        tick();
        expect_reg("R5 resumes", 3'd1, 8'h31);
    endtask

    task automatic t_min_hour();
        wr(3'd2, 8'h59); expect_reg("R6 min 59", 3'd2, 8'h59);
        wr(3'd2, 8'h60); expect_reg("R6 min 60 dropped", 3'd2, 8'h59);
        wr(3'd2, 8'h12); expect_reg("R6 min 12", 3'd2, 8'h12);
        wr(3'd2, 8'hD9); expect_reg("R6 min bit7 masked", 3'd2, 8'h59);
        wr(3'd2, 8'h9A); expect_reg("R6 min bad nibble", 3'd2, 8'h59);
        wr(3'd3, 8'h23); expect_reg("R6 hour 23", 3'd3, 8'h23);
        wr(3'd3, 8'h24); expect_reg("R6 hour 24 dropped", 3'd3, 8'h23);
        wr(3'd3, 8'hC7); expect_reg("R6 hour masked", 3'd3, 8'h07);
    endtask

    task automatic t_wday();
        wr(3'd4, 8'h45); expect_reg("R7 cent+5", 3'd4, 8'h45);
        wr(3'd4, 8'h00); expect_reg("R7 wday 0 dropped, cent cleared", 3'd4, 8'h05);
        wr(3'd4, 8'hBF); expect_reg("R7 wday 7", 3'd4, 8'h07);
    endtask

    task automatic t_date_month_year();
        wr(3'd5, 8'h19); expect_reg("R8 date 19", 3'd5, 8'h19);
        wr(3'd5, 8'h00); expect_reg("R8 date 0 dropped", 3'd5, 8'h19);
        wr(3'd5, 8'h3A); expect_reg("R8 date bad nibble", 3'd5, 8'h19);
        wr(3'd5, 8'h25); expect_reg("R8 date masked", 3'd5, 8'h05);
        wr(3'd6, 8'h12); expect_reg("R8 month 12", 3'd6, 8'h12);
        wr(3'd6, 8'h13); expect_reg("R8 month 13 dropped", 3'd6, 8'h12);
        wr(3'd6, 8'h00); expect_reg("R8 month 0 dropped", 3'd6, 8'h12);
        wr(3'd6, 8'h09); expect_reg("R8 month 9", 3'd6, 8'h09);
        wr(3'd7, 8'h99); expect_reg("R8 year 99", 3'd7, 8'h99);
        wr(3'd7, 8'h9A); expect_reg("R8 year bad", 3'd7, 8'h99);
        wr(3'd7, 8'hA0); expect_reg("R8 year A0", 3'd7, 8'h99);
    endtask

    task automatic t_rollover();
        wr(3'd7, 8'h23); wr(3'd6, 8'h05); wr(3'd5, 8'h19); wr(3'd4, 8'h07);
        wr(3'd3, 8'h23); wr(3'd2, 8'h59); wr(3'd1, 8'h59);
        tick();
        expect_reg("R9 sec wrap", 3'd1, 8'h00);
        expect_reg("R9 min wrap", 3'd2, 8'h00);
        expect_reg("R9 hour wrap", 3'd3, 8'h00);
        expect_reg("R9 wday 7->1", 3'd4, 8'h01);
        expect_reg("R9 date advance", 3'd5, 8'h20);
        expect_reg("R9 month held", 3'd6, 8'h05);
    endtask

    task automatic t_month(input string req, input logic [7:0] mo, input logic [7:0] yr,
                           input int last_bin, input logic [7:0] last_bcd,
                           input logic [7:0] mo_next, input logic [7:0] yr_next);
        wr(3'd7, yr); wr(3'd6, mo); wr(3'd5, 8'h19);
        for (int i = 19; i < last_bin; i++) next_day();
        expect_reg({req, " last day"}, 3'd5, last_bcd);
        expect_reg({req, " month held"}, 3'd6, mo);
        next_day();
        expect_reg({req, " date 01"}, 3'd5, 8'h01);
        expect_reg({req, " month next"}, 3'd6, mo_next);
        expect_reg({req, " year"}, 3'd7, yr_next);
    endtask

    task automatic t_same_cycle();
        wr(3'd1, 8'h10); wr(3'd2, 8'h05);
        @(negedge clk);
        sec_tick = 1'b1; wr_en = 1'b1; addr = 3'd2; wdata = 8'h30;
        @(negedge clk);
        sec_tick = 1'b0; wr_en = 1'b0;
        expect_reg("R12 sec advanced", 3'd1, 8'h11);
        expect_reg("R12 min written", 3'd2, 8'h30);
        @(negedge clk);
        sec_tick = 1'b1; wr_en = 1'b1; addr = 3'd1; wdata = 8'h20;
        @(negedge clk);
        sec_tick = 1'b0; wr_en = 1'b0;
        expect_reg("R12 write wins", 3'd1, 8'h20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_seconds();
        t_min_hour();
        t_wday();
        t_date_month_year();
        t_rollover();
        t_month("R10 april", 8'h04, 8'h23, 30, 8'h30, 8'h05, 8'h23);
        t_month("R10 january", 8'h01, 8'h23, 31, 8'h31, 8'h02, 8'h23);
        t_month("R10 december", 8'h12, 8'h99, 31, 8'h31, 8'h01, 8'h00);
        t_month("R11 feb common", 8'h02, 8'h23, 28, 8'h28, 8'h03, 8'h23);
        t_month("R11 feb leap 24", 8'h02, 8'h24, 29, 8'h29, 8'h03, 8'h24);
        t_month("R11 feb leap 00", 8'h02, 8'h00, 29, 8'h29, 8'h03, 8'h00);
        t_month("R11 feb common 10", 8'h02, 8'h10, 28, 8'h28, 8'h03, 8'h10);
        t_same_cycle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule